// File: doc/BRIEF.md
# Programmable Delay and Pulse Generator

A synchronous timing element that runs on a fast sample clock. Each clock it samples a single-bit input into a line of stored samples. The main output shows the sample that sits at the position chosen by an 8-bit delay code. Because every stored sample is kept, many input transitions can be in transit at once, so a periodic clock can be delayed by one whole period or more. The main output can be inverted. With the output fed back to the input, the block then runs as a free oscillator whose half period is set by the code.

The secondary output has two modes. In reference mode it shows the input delayed only by the fixed latency of code zero, which lets the programmed delay be read as a phase offset. In pulse mode, each rising input edge starts a pulse whose length in clocks equals the code. A `settled` flag reports when the code has stayed unchanged long enough that every stored sample reflects the current code.

The sample stream has no handshake: it advances by one sample on every clock and cannot be held back. The consumer must take each output value in the cycle it appears.

Top module: `prog_delay_pulse`

## Requirements
- R1: With code N and no inversion, a change on `din` sampled at clock edge E appears on `dout` at edge E+N+1, so the bench sees it N+2 sample points after driving.
- R2: The delay line holds every in-flight sample. A square wave with a period shorter than the programmed delay comes out unchanged in shape, delayed by N+1 edges.
- R3: With `pwm_sel`=0, `sec_out` equals `din` delayed by two edges, whatever the code.
- R4: With `pwm_sel`=1, a rising edge of the sampled input drives `sec_out` high, beginning at the same edge the reference copy would rise, for exactly N clocks.
- R5: With `invert_main`=1, `dout` is the logical inverse of the non-inverted delayed value. Feeding `dout` back to `din` gives a square wave with a half period of N+2 clocks.
- R6: `invert_main` has no effect on `sec_out` in reference mode.
- R7: In pulse mode, a code of 0 produces no pulse.
- R8: `settled` goes low on the edge after the code changes. It rises again exactly DEPTH (256) edges after the first edge that sampled the new code.
- R9: The measured delay is monotonic in the code: a larger code never gives a shorter delay.
- R10: A rising edge that arrives in the cycle in which a running pulse would expire reloads the counter. The pulse then continues with no gap.
- R11: During and just after reset, `dout`, `sec_out` and `settled` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Input signal, sampled every clock |
| code | input | 8 | Active delay / pulse-length value |
| invert_main | input | 1 | 1 = invert the main output |
| pwm_sel | input | 1 | 0 = reference copy on sec_out, 1 = pulse output |
| dout | output | 1 | Delayed (optionally inverted) input |
| sec_out | output | 1 | Reference copy or pulse |
| settled | output | 1 | Code unchanged for DEPTH clocks |

## Verification
The pulse counter can be asked to reload and to expire in the same clock. This happens when a second rising edge is detected exactly as the count reaches its last step. The bench provokes this by spacing two input rises by the code value. It then judges that `sec_out` stays high for the combined length, with a single falling edge. Separately, the delay line is loaded with many transitions at once by a fast square wave, and each output sample is compared to the input history.

// File: rtl/dly_pkg.sv
package dly_pkg;
  parameter int DLY_CODE_W = 8;
  typedef enum logic { SEC_REF = 1'b0, SEC_PWM = 1'b1 } sec_mode_e;
endpackage

// File: rtl/dly_tap_line.sv
module dly_tap_line #(
  parameter int CODE_W = 8,
  localparam int DEPTH = 2 ** CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_in,
  input  logic [CODE_W-1:0] sel,
  output logic              tap_zero,
  output logic              tap_one,
  output logic              tap_sel
);
  logic [DEPTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= sample_in;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g] <= 1'b0;
      else        stage[g] <= stage[g-1];
    end
  end

  assign tap_zero = stage[0];
  assign tap_one  = stage[1];
  assign tap_sel  = stage[sel];
endmodule

// File: rtl/dly_pwm_gen.sv
module dly_pwm_gen #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_now,
  input  logic              level_prev,
  input  logic [CODE_W-1:0] length,
  output logic              active
);
  logic [CODE_W-1:0] remain;
  logic              rise;

  assign rise = level_now & ~level_prev;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (rise)           remain <= length;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/dly_settle_mon.sv
module dly_settle_mon #(
  parameter int CODE_W = 8,
  localparam int DEPTH = 2 ** CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              settled
);
  localparam logic [CODE_W:0] FULL = (CODE_W+1)'(DEPTH);

  logic [CODE_W-1:0] code_seen;
  logic [CODE_W:0]   age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_seen <= '0;
      age       <= '0;
    end else begin
      code_seen <= code;
      if (code != code_seen) age <= '0;
      else if (age != FULL)  age <= age + 1'b1;
    end
  end

  assign settled = (age == FULL);
endmodule

// File: rtl/prog_delay_pulse.sv
module prog_delay_pulse #(
  parameter int CODE_W = dly_pkg::DLY_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  input  logic              invert_main,
  input  logic              pwm_sel,
  output logic              dout,
  output logic              sec_out,
  output logic              settled
);
  import dly_pkg::*;

  logic      tap_zero, tap_one, tap_sel;
  logic      main_q, ref_q;
  logic      pulse_active;
  sec_mode_e sec_mode;

  assign sec_mode = sec_mode_e'(pwm_sel);

  dly_tap_line #(.CODE_W(CODE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .sample_in(din), .sel(code),
    .tap_zero(tap_zero), .tap_one(tap_one), .tap_sel(tap_sel)
  );

  dly_pwm_gen #(.CODE_W(CODE_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .level_now(tap_zero), .level_prev(tap_one),
    .length(code), .active(pulse_active)
  );

  dly_settle_mon #(.CODE_W(CODE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .code(code), .settled(settled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      main_q <= tap_sel ^ invert_main;
      ref_q  <= tap_zero;
    end
  end

  assign dout    = main_q;
  assign sec_out = (sec_mode == SEC_PWM) ? pulse_active : ref_q;
endmodule

// File: rtl/prog_delay_pulse_chk.sv
module prog_delay_pulse_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              din,
  input logic [CODE_W-1:0] code,
  input logic              invert_main,
  input logic              pwm_sel,
  input logic              dout,
  input logic              sec_out,
  input logic              settled,
  input logic              pulse_active
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  // R3
  ref_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && !pwm_sel) |-> (sec_out == $past(din, 2)));

  // R1
  zero_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2 && $past(code) == '0) |-> (dout == ($past(din, 2) ^ $past(invert_main))));

  // R8
  settled_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd1 && code != $past(code)) |=> !settled);

  // R7
  pulse_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd1 && $rose(pulse_active)) |-> ($past(code) != '0));
endmodule

bind prog_delay_pulse prog_delay_pulse_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .code(code), .invert_main(invert_main),
  .pwm_sel(pwm_sel), .dout(dout), .sec_out(sec_out), .settled(settled),
  .pulse_active(pulse_active)
);

// File: tb/prog_delay_pulse_bench.sv
module prog_delay_pulse_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din_drv = 1'b0;
  logic fb_en = 1'b0;
  logic [7:0] code = 8'd0;
  logic invert_main = 1'b0;
  logic pwm_sel = 1'b0;
  logic din, dout, sec_out, settled;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  assign din = fb_en ? dout : din_drv;
  always #(CLK_PERIOD/2) clk = ~clk;

  prog_delay_pulse u_prog_delay_pulse (
    .clk(clk), .rst_n(rst_n), .din(din), .code(code), .invert_main(invert_main),
    .pwm_sel(pwm_sel), .dout(dout), .sec_out(sec_out), .settled(settled)
  );

  // {code, invert, pwm, width}
  localparam logic [17:0] VEC [12] = '{
    {8'd0,   1'b0, 1'b0, 8'd3},
    {8'd1,   1'b0, 1'b0, 8'd2},
    {8'd5,   1'b1, 1'b0, 8'd4},
    {8'd17,  1'b0, 1'b0, 8'd1},
    {8'd64,  1'b1, 1'b0, 8'd9},
    {8'd255, 1'b0, 1'b0, 8'd5},
    {8'd0,   1'b0, 1'b1, 8'd4},
    {8'd3,   1'b0, 1'b1, 8'd1},
    {8'd9,   1'b1, 1'b1, 8'd20},
    {8'd100, 1'b0, 1'b1, 8'd2},
    {8'd255, 1'b1, 1'b1, 8'd3},
    {8'd2,   1'b1, 1'b0, 8'd6}
  };
  localparam logic [7:0] MONO [8] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd127, 8'd128, 8'd254, 8'd255};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] c, input logic inv, input logic pwm, input int w,
                         output int m_first, output int m_cnt, output int s_first, output int s_cnt);
    int total;
    @(negedge clk);
    code = c; invert_main = inv; pwm_sel = pwm; din_drv = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);
    m_first = 0; m_cnt = 0; s_first = 0; s_cnt = 0;
    total = int'(c) + w + 12;
    din_drv = 1'b1;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if ((dout ^ inv) == 1'b1) begin
        m_cnt++;
        if (m_first == 0) m_first = k;
      end
      if (sec_out == 1'b1) begin
        s_cnt++;
        if (s_first == 0) s_first = k;
      end
      if (k == w) din_drv = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int mf, mc, sf, sc, prev;
    logic [7:0] c;
    logic inv, pwm;
    int w;

    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 dout in reset", int'(dout), 0);
    check("R11 sec_out in reset", int'(sec_out), 0);
    check("R11 settled in reset", int'(settled), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 dout after reset", int'(dout), 0);
    check("R11 settled after reset", int'(settled), 0);

    // table walk: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < 12; i++) begin
      {c, inv, pwm} = VEC[i][17:8];
      w = int'(VEC[i][7:0]);
      run_vec(c, inv, pwm, w, mf, mc, sf, sc);
      check($sformatf("R1/R5 vec%0d main latency", i), mf, int'(c) + 2);
      check($sformatf("R1/R5 vec%0d main width", i), mc, w);
      if (!pwm) begin
        check($sformatf("R3/R6 vec%0d ref latency", i), sf, 2);
        check($sformatf("R3/R6 vec%0d ref width", i), sc, w);
      end else if (c == 8'd0) begin
        check($sformatf("R7 vec%0d no pulse", i), sc, 0);
      end else begin
        check($sformatf("R4 vec%0d pulse start", i), sf, 2);
        check($sformatf("R4 vec%0d pulse length", i), sc, int'(c));
      end
    end

    // R9 monotonic delay
    prev = 0;
    for (int i = 0; i < 8; i++) begin
      run_vec(MONO[i], 1'b0, 1'b0, 2, mf, mc, sf, sc);
      check("R9 delay equals code+2", mf, int'(MONO[i]) + 2);
      check("R9 delay not shorter", int'(mf >= prev), 1);
      prev = mf;
    end

    // R10 retrigger in the expiry cycle
    begin
      int falls;
      logic last;
      @(negedge clk);
      code = 8'd5; pwm_sel = 1'b1; invert_main = 1'b0; din_drv = 1'b0;
      repeat (20) @(negedge clk);
      sc = 0; falls = 0; last = sec_out;
      for (int k = 1; k <= 30; k++) begin
        din_drv = (k == 1 || k == 6) ? 1'b1 : 1'b0;
        @(negedge clk);
        if (sec_out) sc++;
        if (last && !sec_out) falls++;
        last = sec_out;
      end
      check("R10 merged pulse length", sc, 10);
      check("R10 single falling edge", falls, 1);
    end

    // R2 many transitions in flight
    begin
      logic hist [512];
      int bad;
      @(negedge clk);
      code = 8'd20; pwm_sel = 1'b0; invert_main = 1'b0; din_drv = 1'b0;
      repeat (DEPTH + 4) @(negedge clk);
      for (int k = 0; k < 512; k++) hist[k] = 1'b0;
      bad = 0;
      for (int k = 1; k < 400; k++) begin
        hist[k] = ((k / 3) % 2) == 1;
        din_drv = hist[k];
        @(negedge clk);
        if (k > 23 && dout != hist[k - 21]) bad++;
      end
      check("R2 delayed square wave mismatches", bad, 0);
    end

    // R5 free-running oscillator
    begin
      int last_t, t;
      logic last;
      @(negedge clk);
      code = 8'd3; invert_main = 1'b1; pwm_sel = 1'b0; din_drv = 1'b0;
      repeat (DEPTH + 4) @(negedge clk);
      fb_en = 1'b1;
      repeat (40) @(negedge clk);
      last = dout; last_t = -1; t = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (dout != last) begin
          if (last_t >= 0 && t < 4) begin
            check("R5 oscillator half period", k - last_t, 5);
            t++;
          end
          last_t = k;
        end
        last = dout;
      end
      check("R5 oscillator toggled", t, 4);
      fb_en = 1'b0;
    end

    // R8 settling flag
    @(negedge clk);
    code = 8'd0; invert_main = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);
    check("R8 settled after long hold", int'(settled), 1);
    code = 8'd7;
    for (int j = 0; j <= DEPTH; j++) begin
      @(negedge clk);
      if (j == 0) check("R8 settled drops", int'(settled), 0);
      if (j == DEPTH - 1) check("R8 settled still low", int'(settled), 0);
      if (j == DEPTH) check("R8 settled rises", int'(settled), 1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule